// File: doc/BRIEF.md
# Programmable Countdown Timer with Power-of-Two Prescaler

This block is the timer inside a local interrupt controller. Software reaches it through a simple register bus that is one word wide. The block has four registers: a mode register, an initial-count register, a read-only current-count register and a divide-configuration register. A prescaler divides the bus clock by a power of two. The divide-configuration register selects that power through a 3-bit code gathered from non-adjacent bits.

Writing a non-zero initial count starts a countdown at once. The current count drops by one on every prescaler tick. When the count runs out, the block raises a one-cycle expiry pulse on `expire_o`. In one-shot mode the count then rests at zero. In periodic mode it reloads from the initial count and counts down again. Writing an initial count of zero stops the timer.

The asynchronous active-low reset is released synchronously inside the block, two clock edges after `rst_n` rises.

Top module: `irq_countdown_timer`

## Requirements
- R1: A write to the divide register (word offset 3) keeps only bits 3, 1 and 0 of the write data. A read of offset 3 returns those bits, and all other bits read as zero.
- R2: The divisor code is {bit3, bit1, bit0} of the divide register. The divisor is 2 raised to ((code + 1) mod 8). Code 000 gives 2, code 110 gives 128 and code 111 gives 1.
- R3: After reset, every register reads zero, the divisor is 2 and `expire_o` is low.
- R4: A write to the initial-count register (offset 1) loads the same value into the current count and restarts the prescaler phase. The first decrement follows exactly one divisor's worth of cycles after that write edge.
- R5: While the timer runs, the current count (read at offset 2) drops by exactly one per prescaler tick and holds its value between ticks.
- R6: In periodic mode (mode register bit 0 = 1), a tick that finds the count at 1 reloads the initial count instead of reaching zero, so each period lasts the same number of ticks.
- R7: In one-shot mode (bit 0 = 0), the tick that finds the count at 1 sets it to 0. The count then stays at 0, with no further pulses, until the next initial-count write.
- R8: `expire_o` is high for exactly the one cycle that follows the clock edge at which the count expires, and is low at all other times.
- R9: Writing an initial count of zero stops the timer, leaves the current count at zero and produces no expiry pulse.
- R10: Bus writes to the current-count register (offset 2) are ignored.
- R11: A read at any offset above 3 returns zero, and writes there change nothing.
- R12: The prescaler phase counts up by one each cycle while the timer runs. A tick occurs when the phase is at least divisor-1, and the phase then returns to 0. A divide-register write does not clear the phase or the current count, so a new divisor applies from the next boundary.
- R13: The mode register (offset 0) keeps only bit 0, and all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| expire_o | output | 1 | One-cycle expiry pulse |

## Verification
A wrong prescaler phase or a wrong divisor decode moves the decrement of the current count. Offset 2 shows that move on the first tick after the fault, within at most 128 cycles. A wrong count or reload shows up as a misplaced or missing `expire_o` pulse at the end of the period in which it happens. A bad register mask shows on the very next read of that offset. The bench's model predicts the current count and the pulse for every cycle, so any such drift is reported in the cycle where it first appears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFF_MODE = 0;
  localparam int unsigned OFF_INIT = 1;
  localparam int unsigned OFF_CUR  = 2;
  localparam int unsigned OFF_DIV  = 3;
  localparam int unsigned SHIFT_W  = 3;
  localparam int unsigned PHASE_W  = (1 << SHIFT_W) - 1;

  // scrambled code -> power of two exponent
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [SHIFT_W-1:0] code);
    return code + 1'b1;
  endfunction
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cur_cnt,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  init_val,
  output logic              periodic,
  output logic [SHIFT_W-1:0] div_code
);
  logic              mode_q, mode_d, mode_en;
  logic [CNT_W-1:0]  init_q, init_d;
  logic [SHIFT_W-1:0] code_q, code_d;
  logic              code_en;

  always_comb begin
    mode_en = bus_wr && (bus_addr == ADDR_W'(OFF_MODE));
    code_en = bus_wr && (bus_addr == ADDR_W'(OFF_DIV));
    load    = bus_wr && (bus_addr == ADDR_W'(OFF_INIT));
    mode_d  = bus_wdata[0];
    code_d  = {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
    init_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      init_q <= '0;
      code_q <= '0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (load)    init_q <= init_d;
      if (code_en) code_q <= code_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_MODE): bus_rdata[0] = mode_q;
      ADDR_W'(OFF_INIT): bus_rdata    = init_q;
      ADDR_W'(OFF_CUR):  bus_rdata    = cur_cnt;
      ADDR_W'(OFF_DIV):  bus_rdata[3:0] = {code_q[2], 1'b0, code_q[1:0]};
      default:           bus_rdata    = '0;
    endcase
  end

  assign load_val = bus_wdata;
  assign init_val = init_q;
  assign periodic = mode_q;
  assign div_code = code_q;

  // R1
  div_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_DIV)) |-> (bus_rdata[2] == 1'b0 && bus_rdata[CNT_W-1:4] == '0));
  // R11
  high_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(OFF_DIV)) |-> (bus_rdata == '0));
  // R13
  mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_MODE)) |-> (bus_rdata[CNT_W-1:1] == '0));
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] div_code,
  output logic               tick
);
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [PHASE_W:0]   div_full;
  logic [PHASE_W-1:0] div_m1;

  always_comb begin
    div_full = (PHASE_W+1)'(1) << code_to_shift(div_code);
    div_m1   = PHASE_W'(div_full - 1'b1);
    tick     = run && (phase_q >= div_m1);
    if (restart || !run || tick) phase_d = '0;
    else                         phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R12
  phase_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !restart) |=> (phase_q == $past(phase_q) + 1'b1));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_val,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] cur_cnt,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] cur_q, cur_d;
  logic             run_q, run_d, irq_q, irq_d;

  always_comb begin
    cur_d = cur_q;
    run_d = run_q;
    irq_d = 1'b0;
    if (load) begin
      cur_d = load_val;
      run_d = |load_val;
    end else if (tick) begin
      if (cur_q == CNT_W'(1)) begin
        irq_d = 1'b1;
        if (periodic) begin
          cur_d = init_val;
        end else begin
          cur_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cur_d = cur_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      run_q <= run_d;
      irq_q <= irq_d;
    end
  end

  assign cur_cnt = cur_q;
  assign running = run_q;
  assign expire  = irq_q;

  // R4
  load_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_q == $past(load_val)));
  // R5
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cur_q));
  // R8
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(cur_q) == CNT_W'(1)));
  // R7
  oneshot_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !$past(periodic)) |-> (cur_q == '0 && !run_q));
  // R9
  zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (!irq_q && !run_q));
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              expire_o
);
  logic               rst_sync_n;
  logic               load, periodic, tick, running;
  logic [CNT_W-1:0]   load_val, init_val, cur_cnt;
  logic [SHIFT_W-1:0] div_code;

  tmr_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .cur_cnt(cur_cnt), .bus_rdata(bus_rdata),
    .load(load), .load_val(load_val), .init_val(init_val),
    .periodic(periodic), .div_code(div_code)
  );

  tmr_prescale u_pre (
    .clk(clk), .rst_n(rst_sync_n), .run(running), .restart(load),
    .div_code(div_code), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .load_val(load_val),
    .init_val(init_val), .periodic(periodic), .tick(tick),
    .cur_cnt(cur_cnt), .running(running), .expire(expire_o)
  );
endmodule

// File: tb/irq_countdown_timer_test.sv
`timescale 1ns/100ps
module irq_countdown_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        expire_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string req = "R3";

  // reference model state
  int unsigned m_cur, m_init, m_phase;
  bit m_per, m_run, m_irq;
  logic [3:0] m_divr;

  always #2.5 clk = ~clk;

  irq_countdown_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire_o(expire_o)
  );

  function automatic int unsigned model_div();
    int code;
    code = {m_divr[3], m_divr[1], m_divr[0]};
    return 1 << ((code + 1) % 8);
  endfunction

  function automatic logic [31:0] model_read(input int a);
    case (a)
      0: return {31'b0, m_per};
      1: return m_init;
      2: return m_cur;
      3: return {28'b0, m_divr};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // one bus cycle: drive, compare, advance the model across the next edge
  task automatic cyc(input int a, input bit w, input logic [31:0] d);
    bit tk, nirq;
    @(negedge clk);
    bus_addr = a[3:0]; bus_wr = w; bus_wdata = d;
    #1;
    check("rdata", bus_rdata, model_read(a));
    check("expire", {31'b0, expire_o}, {31'b0, m_irq});
    nirq = 0;
    tk = m_run && (m_phase + 1 >= model_div());
    if (w && a == 1) begin
      m_init = d; m_cur = d; m_phase = 0; m_run = (d != 0);
    end else begin
      if (tk) begin
        m_phase = 0;
        if (m_cur == 1) begin
          nirq = 1;
          if (m_per) m_cur = m_init;
          else begin m_cur = 0; m_run = 0; end
        end else m_cur = m_cur - 1;
      end else if (m_run) m_phase++;
      else m_phase = 0;
    end
    m_irq = nirq;
    if (w && a == 0) m_per = d[0];
    if (w && a == 3) m_divr = d[3:0] & 4'hB;
  endtask

  task automatic idle(input int a, input int n);
    for (int i = 0; i < n; i++) cyc(a, 0, 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    m_cur = 0; m_init = 0; m_phase = 0; m_per = 0; m_run = 0; m_irq = 0; m_divr = 0;
    // R3: reset values, model held in reset
    for (int i = 0; i < 4; i++) cyc(i, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    req = "R3";
    for (int i = 0; i < 4; i++) cyc(i, 0, 0);

    // R1: mask of divide register
    req = "R1";
    cyc(3, 1, 32'hFFFF_FFFF); cyc(3, 0, 0);
    cyc(3, 1, 32'h0000_0004); cyc(3, 0, 0);
    cyc(3, 1, 32'h0);         cyc(3, 0, 0);

    // R13: mode register keeps bit 0 only
    req = "R13";
    cyc(0, 1, 32'hFFFF_FFFE); cyc(0, 0, 0);
    cyc(0, 1, 32'h0);         cyc(0, 0, 0);

    // R4, R5, R7, R8: one-shot at divide-by-2
    req = "R4";
    cyc(1, 1, 5); idle(2, 4);
    req = "R5"; idle(2, 4);
    req = "R7"; idle(2, 10);
    req = "R8"; idle(2, 4);

    // R10: writes to current count ignored mid-run
    req = "R10";
    cyc(1, 1, 20); idle(2, 5);
    cyc(2, 1, 32'h63); idle(2, 5);
    cyc(2, 1, 32'h1); idle(2, 50);

    // R6: periodic, divide-by-1 (code 111)
    req = "R6";
    cyc(0, 1, 1); cyc(3, 1, 32'hB);
    cyc(1, 1, 3); idle(2, 14);
    cyc(1, 1, 1); idle(2, 6);

    // R2: every divide encoding, periodic count of 2
    req = "R2";
    for (int v = 0; v < 16; v++) begin
      cyc(3, 1, v);
      cyc(1, 1, 2);
      idle(2, 5 * model_div() + 3);
    end

    // R12: divisor change during countdown
    req = "R12";
    cyc(0, 1, 0); cyc(3, 1, 32'h3);
    cyc(1, 1, 10); idle(2, 20);
    cyc(3, 1, 32'h0); idle(2, 12);
    cyc(3, 1, 32'h9); idle(2, 80);
    cyc(3, 1, 32'h2); idle(2, 60);

    // R9: zero initial count stops the timer
    req = "R9";
    cyc(0, 1, 1); cyc(3, 1, 0);
    cyc(1, 1, 4); idle(2, 3);
    cyc(1, 1, 0); idle(2, 30);

    // R11: offsets above 3 read zero, writes there ignored
    req = "R11";
    for (int a = 4; a < 16; a++) begin
      cyc(a, 1, 32'hDEAD_BEEF);
      cyc(a, 0, 0);
    end
    for (int a = 0; a < 4; a++) cyc(a, 0, 0);

    done = 1;
    finish_up();
  end
endmodule